// File: doc/BRIEF.md
# Serial Overhead Byte Capture Port

This block loads the orderwire and data-channel overhead bytes of a transmit framer from a slow bit-serial line. Once per frame a frame-start strobe arms it. On the next serial clock slot it drives a one-slot frame pulse. It then takes a gap-free burst of 14 bytes, each sent MSB first. The byte positions are fixed: entry 0 is the first orderwire byte, entries 1 to 12 are the twelve data-channel bytes, and entry 13 is the second orderwire byte.

The serial clock is a one-cycle enable strobe made from the system clock by a programmable divider. A per-byte enable line is looked at only in the MSB slot of each byte. A low value there leaves that entry untouched. A control processor can also write the same 14-entry register file, and a read port serves the overhead inserter. An entry keeps its stored value across frames until new serial input or a processor write replaces it.

Top module: `ohb_serial_capture`

## Requirements
- R1: While reset is applied and just after it, every entry reads 0 and `frame_pulse` is low.
- R2: `ser_tick` is high for one system clock cycle once every `div_val`+1 cycles. When `div_val` is 0 it stays high on every cycle.
- R3: After a `frame_start` pulse, `frame_pulse` is high together with the first following `ser_tick`. It is high on no other tick of that frame.
- R4: The 112 ticks after the pulse tick carry the bytes for entries 0 to 13 in order, 8 ticks per byte, MSB first. The tick after the pulse tick is the MSB of entry 0.
- R5: `ser_byte_en` is sampled only on the MSB tick of each byte. If it is 1 there, the byte is stored. If it is 0, the entry keeps its old value. Its level on the other seven ticks has no effect.
- R6: An entry changes only on the clock edge of its byte's eighth tick. Before that edge it still reads its old value, and from the next cycle it reads the new byte.
- R7: Stored values persist across later frames and idle time until they are overwritten.
- R8: When `cpu_wr` is 1, `cpu_wdata` is written to entry `cpu_addr` and can be read on the next cycle. Addresses 14 and 15 write nothing.
- R9: If a serial store and a processor write hit the same entry on the same edge, the serial byte is kept.
- R10: A `frame_start` that arrives while a frame is armed or in its burst is ignored. No second frame pulse follows that burst.
- R11: `rd_data` returns entry `rd_addr` combinationally, and returns 0 for addresses 14 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Serial tick divider, period is div_val+1 cycles |
| frame_start | input | 1 | Arms one capture burst |
| ser_data | input | 1 | Serial overhead data, MSB first |
| ser_byte_en | input | 1 | Per-byte store enable, sampled in the MSB slot |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | ADDR_W | Processor write entry |
| cpu_wdata | input | BYTE_W | Processor write data |
| rd_addr | input | ADDR_W | Read entry for the inserter |
| ser_tick | output | 1 | Serial clock enable strobe |
| frame_pulse | output | 1 | Marks the slot before the first MSB |
| rd_data | output | BYTE_W | Entry read data |

## Verification
The bench goes after the one-slot offset between the frame pulse and the first MSB. A design that is off by one slot would store every byte rotated by one bit. It drives the enable line opposite to its MSB value on the other seven bits, so a design that samples the enable late or keeps re-sampling it would store disabled bytes or drop enabled ones. It reads each entry just before and just after its eighth tick, which exposes a register file that updates bit by bit. It also forces a processor write onto the same entry and the same edge as a serial store, and restarts a frame in the middle of a burst, which catches the wrong write priority and a sequencer that re-arms itself.

// File: rtl/ohb_cap_pkg.sv
package ohb_cap_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_BURST = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ohb_tick_div.sv
module ohb_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  // >= keeps the strobe alive if div_val is lowered below the count
  always_comb begin
    tick  = (cnt_q >= div_val);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ohb_burst_seq.sv
module ohb_burst_seq
  import ohb_cap_pkg::*;
#(
  parameter  int NUM_BYTES = 14,
  parameter  int BYTE_W    = 8,
  localparam int IDX_W     = $clog2(NUM_BYTES),
  localparam int BIT_W     = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              frame_start,
  input  logic              ser_data,
  input  logic              ser_byte_en,
  output logic              frame_pulse,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] BYTE_LAST = IDX_W'(NUM_BYTES - 1);

  seq_state_e        state_q, state_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [IDX_W-1:0]  byte_q, byte_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              keep_q, keep_d;

  always_comb begin
    state_d     = state_q;
    bit_d       = bit_q;
    byte_d      = byte_q;
    shift_d     = shift_q;
    keep_d      = keep_q;
    frame_pulse = 1'b0;
    wr_en       = 1'b0;
    wr_idx      = byte_q;
    wr_data     = {shift_q[BYTE_W-2:0], ser_data};
    case (state_q)
      SEQ_IDLE: begin
        if (frame_start) state_d = SEQ_ARMED;
      end
      SEQ_ARMED: begin
        if (tick) begin
          frame_pulse = 1'b1;
          state_d     = SEQ_BURST;
          bit_d       = '0;
          byte_d      = '0;
        end
      end
      SEQ_BURST: begin
        if (tick) begin
          shift_d = wr_data;
          if (bit_q == '0) keep_d = ser_byte_en;
          if (bit_q == BIT_LAST) begin
            wr_en = keep_q;
            bit_d = '0;
            if (byte_q == BYTE_LAST) state_d = SEQ_IDLE;
            else                     byte_d  = byte_q + 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      shift_q <= '0;
      keep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      shift_q <= shift_d;
      keep_q  <= keep_d;
    end
  end
endmodule

// File: rtl/ohb_reg_file.sv
module ohb_reg_file #(
  parameter  int NUM_BYTES = 14,
  parameter  int BYTE_W    = 8,
  localparam int IDX_W     = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_wr,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              c_wr,
  input  logic [IDX_W-1:0]  c_idx,
  input  logic [BYTE_W-1:0] c_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] mem_q [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_entry
    logic              s_hit, c_hit;
    logic [BYTE_W-1:0] ent_d;
    always_comb begin
      s_hit = s_wr && (s_idx == IDX_W'(g));
      c_hit = c_wr && (c_idx == IDX_W'(g));
      // serial capture has priority over the processor
      ent_d = s_hit ? s_data : (c_hit ? c_data : mem_q[g]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              mem_q[g] <= '0;
      else if (s_hit || c_hit) mem_q[g] <= ent_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = mem_q[i];
    end
  end
endmodule

// File: rtl/ohb_serial_capture.sv
module ohb_serial_capture #(
  parameter  int DIV_W     = 8,
  parameter  int NUM_BYTES = 14,
  parameter  int BYTE_W    = 8,
  localparam int ADDR_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              frame_start,
  input  logic              ser_data,
  input  logic              ser_byte_en,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              ser_tick,
  output logic              frame_pulse,
  output logic [BYTE_W-1:0] rd_data
);
  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic              ser_wr;
  logic [ADDR_W-1:0] ser_idx;
  logic [BYTE_W-1:0] ser_wdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  ohb_tick_div #(.DIV_W(DIV_W)) i_div (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .div_val (div_val),
    .tick    (ser_tick)
  );

  ohb_burst_seq #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .tick        (ser_tick),
    .frame_start (frame_start),
    .ser_data    (ser_data),
    .ser_byte_en (ser_byte_en),
    .frame_pulse (frame_pulse),
    .wr_en       (ser_wr),
    .wr_idx      (ser_idx),
    .wr_data     (ser_wdata)
  );

  ohb_reg_file #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .s_wr    (ser_wr),
    .s_idx   (ser_idx),
    .s_data  (ser_wdata),
    .c_wr    (cpu_wr),
    .c_idx   (cpu_addr),
    .c_data  (cpu_wdata),
    .rd_idx  (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/ohb_serial_capture_chk.sv
module ohb_serial_capture_chk #(
  parameter int DIV_W     = 8,
  parameter int NUM_BYTES = 14,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 4
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic [DIV_W-1:0]  div_val,
  input logic              ser_tick,
  input logic              frame_pulse,
  input logic              ser_wr,
  input logic [ADDR_W-1:0] ser_idx,
  input logic [BYTE_W-1:0] ser_wdata,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BYTE_W-1:0] rd_data
);
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ser_tick && div_val != '0) |=> (!ser_tick || !$stable(div_val)));

  p_pulse_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    frame_pulse |-> ser_tick);

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    frame_pulse |=> !frame_pulse);

  p_store_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    ser_wr |-> ser_tick);

  p_store_in_range_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    ser_wr |-> (ser_idx < ADDR_W'(NUM_BYTES)));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ser_wr && !cpu_wr) |=> (!$stable(rd_addr) || $stable(rd_data)));

  p_serial_wins_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ser_wr && cpu_wr && cpu_addr == ser_idx)
      |=> (rd_addr != $past(ser_idx) || rd_data == $past(ser_wdata)));
endmodule

bind ohb_serial_capture ohb_serial_capture_chk #(
  .DIV_W(DIV_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .div_val     (div_val),
  .ser_tick    (ser_tick),
  .frame_pulse (frame_pulse),
  .ser_wr      (ser_wr),
  .ser_idx     (ser_idx),
  .ser_wdata   (ser_wdata),
  .cpu_wr      (cpu_wr),
  .cpu_addr    (cpu_addr),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data)
);

// File: tb/test_ohb_serial_capture.sv
module test_ohb_serial_capture;
  logic       clk;
  logic       rst_n;
  logic [7:0] div_val;
  logic       frame_start;
  logic       ser_data;
  logic       ser_byte_en;
  logic       cpu_wr;
  logic [3:0] cpu_addr;
  logic [7:0] cpu_wdata;
  logic [3:0] rd_addr;
  logic       ser_tick;
  logic       frame_pulse;
  logic [7:0] rd_data;

  int total = 0;
  int bad   = 0;
  logic [7:0]  exp_mem  [14];
  logic [7:0]  tx_bytes [14];
  logic [13:0] tx_en;

  ohb_serial_capture i_ohb_serial_capture (
    .clk, .rst_n, .div_val, .frame_start, .ser_data, .ser_byte_en,
    .cpu_wr, .cpu_addr, .cpu_wdata, .rd_addr,
    .ser_tick, .frame_pulse, .rd_data
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_entry(input int a, input string req);
    rd_addr = 4'(a);
    #1;
    chk(rd_data == exp_mem[a], req, int'(rd_data), int'(exp_mem[a]));
  endtask

  task automatic test_reset();
    rst_n = 1'b0; div_val = 8'd3; frame_start = 1'b0; ser_data = 1'b0;
    ser_byte_en = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0; rd_addr = '0;
    for (int i = 0; i < 14; i++) exp_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk(frame_pulse == 1'b0, "R1 pulse in reset", int'(frame_pulse), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(frame_pulse == 1'b0, "R1 pulse after reset", int'(frame_pulse), 0);
    for (int i = 0; i < 14; i++) read_entry(i, "R1 entry");
  endtask

  task automatic test_tick_period(input int dv);
    int gap;
    div_val = 8'(dv);
    repeat (12) @(negedge clk);
    while (!ser_tick) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (!ser_tick) begin
      @(negedge clk);
      gap++;
    end
    chk(gap == dv + 1, "R2 tick period", gap, dv + 1);
  endtask

  // collide_b: entry hit by a processor write on its eighth tick (-1: none)
  // restart_b: byte during which frame_start is pulsed again (-1: none)
  task automatic run_frame(input int collide_b, input bit glitch, input int restart_b);
    int extra = 0;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    while (!ser_tick) @(negedge clk);
    chk(frame_pulse == 1'b1, "R3 pulse on first tick", int'(frame_pulse), 1);
    @(negedge clk);
    for (int b = 0; b < 14; b++) begin
      for (int i = 0; i < 8; i++) begin
        while (!ser_tick) @(negedge clk);
        if (frame_pulse) extra++;
        ser_data    = tx_bytes[b][7-i];
        ser_byte_en = (i == 0) ? tx_en[b] : (glitch ? !tx_en[b] : tx_en[b]);
        if (b == restart_b && i == 3) frame_start = 1'b1;
        if (i == 7) begin
          read_entry(b, "R6 old value before eighth tick");
          if (b == collide_b) begin
            cpu_wr = 1'b1; cpu_addr = 4'(b); cpu_wdata = ~tx_bytes[b];
          end
        end
        @(negedge clk);
        cpu_wr = 1'b0;
        frame_start = 1'b0;
        if (i == 7) begin
          if (tx_en[b]) exp_mem[b] = tx_bytes[b];
          if (b == collide_b) read_entry(b, "R9 serial wins");
          else if (glitch)    read_entry(b, "R5 enable at MSB only");
          else                read_entry(b, "R4 byte order");
        end
      end
    end
    chk(extra == 0, "R3 no pulse inside burst", extra, 0);
    if (restart_b >= 0) begin
      int seen = 0;
      repeat (60) begin
        @(negedge clk);
        if (frame_pulse) seen++;
      end
      chk(seen == 0, "R10 restart ignored", seen, 0);
    end
  endtask

  task automatic test_cpu_port();
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = 4'd2;  cpu_wdata = 8'h5C;
    @(negedge clk); cpu_addr = 4'd13; cpu_wdata = 8'hE7; exp_mem[2] = 8'h5C;
    @(negedge clk); cpu_addr = 4'd14; cpu_wdata = 8'hFF; exp_mem[13] = 8'hE7;
    @(negedge clk); cpu_addr = 4'd15;
    @(negedge clk); cpu_wr = 1'b0;
    for (int i = 0; i < 14; i++) read_entry(i, "R8 processor write");
    rd_addr = 4'd14; #1;
    chk(rd_data == 8'h00, "R11 read addr 14", int'(rd_data), 0);
    rd_addr = 4'd15; #1;
    chk(rd_data == 8'h00, "R11 read addr 15", int'(rd_data), 0);
  endtask

  initial begin
    #3_000_000;
    bad++;
    total++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_tick_period(3);
    test_tick_period(5);
    test_tick_period(0);
    div_val = 8'd3;
    for (int b = 0; b < 14; b++) tx_bytes[b] = 8'(8'h11 * b + 8'h03);
    tx_en = 14'h3FFF;
    run_frame(-1, 1'b0, -1);
    test_cpu_port();
    for (int b = 0; b < 14; b++) tx_bytes[b] = 8'(8'hA7 ^ (b * 8'h1D));
    tx_en = 14'b10_1010_0110_1001;
    run_frame(-1, 1'b1, -1);
    div_val = 8'd0;
    for (int b = 0; b < 14; b++) tx_bytes[b] = 8'(8'h80 >> (b % 8)) ^ 8'(b);
    tx_en = 14'h3FFF;
    run_frame(5, 1'b0, -1);
    div_val = 8'd2;
    for (int b = 0; b < 14; b++) tx_bytes[b] = 8'hFF;
    tx_en = 14'h0000;
    run_frame(-1, 1'b0, 4);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 14; i++) read_entry(i, "R7 values persist");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule